// File: doc/BRIEF.md
# Rate-Multiplier Frequency Synthesizer

This block makes a slow square wave whose frequency is a finely settable fraction of a fixed clock. It has two parts. The first is a decimal rate multiplier. It lets through, on average, N of every 10^k clock cycles, where N is a k-digit BCD setting. The second is a divider chain that reduces that pulse stream to the final square wave. With the defaults (five digits, four divider stages, a 1 MHz clock) a setting of 60165 gives about 60.165 Hz.

The rate multiplier is a cascade of decade counters. The most significant counter advances every cycle. Each lower counter advances only in cycles where every counter above it holds 9, so each decade runs at one tenth of the rate of the decade above it. A decade lets a pulse through on exactly d of its states 0..8, where d is its digit, and never on state 9. Two decades therefore never fire in the same cycle. Output pulses always fall on clock cycles, so they are unevenly spaced; only the average rate is exact.

The divider chain has three kinds of stage:
- Plain decade stages, each dividing by 10.
- One switchable stage that can divide by 9, 10 or 11 to steer the output up or down by 10%. It is a 4-bit counter that counts up to 15 and then reloads, on the same step, from a preload value that sets its modulus.
- A final stage that divides by 5 and then by 2, giving a 50% duty output. It is a ten-state machine:
  - Low states LO0 to LO4 drive the output low.
  - High states HI0 to HI4 drive it high.
  - Each carry from the stage before moves the machine to the next state, in the order LO0 to LO4, then HI0 to HI4, then back to LO0.
  - Reset enters LO0.

Top module: `rate_synth`

## Requirements
- R1: Counting from the clock edge that leaves reset, mul_pulse is high in exactly N of the first 10^k cycles, and in exactly N of each later block of 10^k cycles. N is read from bcd_set: bits [3:0] are the least significant digit and bits [4k-1:4k-4] the most significant.
- R2: A setting of all zeros produces no mul_pulse at all.
- R3: A BCD digit above 9 counts as 9. With k=3, for example, 0x1F0 gives 190 pulses and 0xFFF gives 999.
- R4: bcd_set is captured while reset is held, and after that only on the last cycle of each 10^k-cycle period, when every decade counter holds 9. A change made earlier in a period does not alter that period's count. A change made in the period's last cycle governs the next period.
- R5: The reset is synchronous and active high. It clears all counters, holds mul_pulse and sq_out low, and puts the final stage in LO0.
- R6: With guide_up and guide_dn both low, each full sq_out period (one rising edge to the next) spans exactly 10^S mul_pulse pulses, where S is the number of divider stages.
- R7: The switchable stage chooses its modulus whenever it reloads. Its preload is the 4-bit complement of the setting, so a setting of m divides by m+1:
  - guide_up alone: preload 7, divide by 9, period 9·10^(S-1) pulses.
  - guide_dn alone: preload 5, divide by 11, period 11·10^(S-1) pulses.
  - Both or neither: preload 6, divide by 10.
- R8: sq_out is high for exactly half the pulses of each period, and it changes only on a step that comes from the stage before the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate input clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_set | input | 4*DIGITS | BCD rate setting; the least significant digit is in bits [3:0] |
| guide_up | input | 1 | Steer the output 10% higher |
| guide_dn | input | 1 | Steer the output 10% lower |
| mul_pulse | output | 1 | Rate-multiplier output, one cycle per pulse |
| sq_out | output | 1 | Final square wave |

## Verification
The setting reload and a new value on bcd_set can fall in the same cycle. This is the last cycle of a period, when every decade holds 9. The bench changes the setting once in the middle of a period and again in that final cycle. It then expects the old count for the current period and the value written last for the next period. The switchable stage's reload and a guide setting also meet on one step. That case is judged by measuring the high time and the full period in multiplier pulses after the chain has settled.

// File: rtl/rsyn_pkg.sv
package rsyn_pkg;

    typedef logic [3:0] bcd_t;

    // Decade gate: a decade holding count c fires on exactly d of states 0..8.
    // It never fires on 9, the only state in which a lower decade is advancing.
    function automatic logic gate_hit(bcd_t c, bcd_t d);
        int a;
        int b;
        if (c > 4'd8) return 1'b0;
        a = ((int'(c) + 1) * int'(d)) / 9;
        b = (int'(c) * int'(d)) / 9;
        return a != b;
    endfunction

    function automatic bcd_t clamp_digit(bcd_t d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

    typedef enum logic [3:0] {
        PH_LO0, PH_LO1, PH_LO2, PH_LO3, PH_LO4,
        PH_HI0, PH_HI1, PH_HI2, PH_HI3, PH_HI4
    } half_state_t;

endpackage

// File: rtl/rsyn_rate_mult.sv
module rsyn_rate_mult
    import rsyn_pkg::*;
#(
    parameter int DIGITS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [4*DIGITS-1:0]   bcd_set,
    output logic                  pulse_o
);
    logic [DIGITS-1:0][3:0] cnt_q;
    logic [DIGITS-1:0][3:0] set_q;
    logic [DIGITS-1:0]      en;
    logic [DIGITS-1:0]      hit;
    logic                   wrap;

    // A decade is enabled when every decade above it holds 9.
    always_comb begin
        for (int i = 0; i < DIGITS; i++) begin
            logic e;
            e = 1'b1;
            for (int j = i + 1; j < DIGITS; j++) begin
                e = e & (cnt_q[j] == 4'd9);
            end
            en[i]  = e;
            hit[i] = e & gate_hit(cnt_q[i], set_q[i]);
        end
        wrap = en[0] & (cnt_q[0] == 4'd9);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= 1'b0;
            for (int i = 0; i < DIGITS; i++) begin
                cnt_q[i] <= 4'd0;
                set_q[i] <= clamp_digit(bcd_set[4*i +: 4]);
            end
        end else begin
            pulse_o <= |hit;
            for (int i = 0; i < DIGITS; i++) begin
                if (en[i]) cnt_q[i] <= (cnt_q[i] == 4'd9) ? 4'd0 : cnt_q[i] + 4'd1;
                if (wrap)  set_q[i] <= clamp_digit(bcd_set[4*i +: 4]);
            end
        end
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_chk
        assert_decade_range_R1: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] <= 4'd9);
        assert_digit_clamp_R3: assert property (@(posedge clk) disable iff (rst)
            set_q[g] <= 4'd9);
    end

    assert_set_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(set_q));

    assert_zero_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (set_q == '0) |=> !pulse_o);

endmodule

// File: rtl/rsyn_decade.sv
module rsyn_decade (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic carry_o
);
    logic [3:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= 4'd0;
        else if (step_i) cnt_q <= (cnt_q == 4'd9) ? 4'd0 : cnt_q + 4'd1;
    end

    assign carry_o = step_i & (cnt_q == 4'd9);

    assert_dec_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= 4'd9);

endmodule

// File: rtl/rsyn_guided_stage.sv
module rsyn_guided_stage (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    input  logic guide_up,
    input  logic guide_dn,
    output logic carry_o
);
    logic [3:0] cnt_q;
    logic [3:0] load_val;

    // Preload is the complement of the modulus setting m; counting to 15 divides by m+1.
    always_comb begin
        unique case ({guide_up, guide_dn})
            2'b10:   load_val = 4'd7;   // setting 8  -> divide by 9
            2'b01:   load_val = 4'd5;   // setting 10 -> divide by 11
            default: load_val = 4'd6;   // setting 9  -> divide by 10
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= load_val;
        else if (step_i) cnt_q <= (cnt_q == 4'hF) ? load_val : cnt_q + 4'd1;
    end

    assign carry_o = step_i & (cnt_q == 4'hF);

    assert_reload_set_R7: assert property (@(posedge clk) disable iff (rst)
        (step_i && cnt_q == 4'hF) |=> (cnt_q >= 4'd5 && cnt_q <= 4'd7));

    assert_floor_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q >= 4'd5);

endmodule

// File: rtl/rsyn_half_fsm.sv
module rsyn_half_fsm
    import rsyn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic sq_o
);
    half_state_t state_q;
    half_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_LO0;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (step_i) begin
            unique case (state_q)
                PH_LO0:  state_d = PH_LO1;
                PH_LO1:  state_d = PH_LO2;
                PH_LO2:  state_d = PH_LO3;
                PH_LO3:  state_d = PH_LO4;
                PH_LO4:  state_d = PH_HI0;
                PH_HI0:  state_d = PH_HI1;
                PH_HI1:  state_d = PH_HI2;
                PH_HI2:  state_d = PH_HI3;
                PH_HI3:  state_d = PH_HI4;
                PH_HI4:  state_d = PH_LO0;
                default: state_d = PH_LO0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            PH_HI0, PH_HI1, PH_HI2, PH_HI3, PH_HI4: sq_o = 1'b1;
            default:                                sq_o = 1'b0;
        endcase
    end

    assert_sq_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sq_o) |-> $past(step_i));

endmodule

// File: rtl/rate_synth.sv
module rate_synth #(
    parameter int DIGITS      = 5,
    parameter int DIV_STAGES  = 4,
    parameter int GUIDE_STAGE = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [4*DIGITS-1:0] bcd_set,
    input  logic                guide_up,
    input  logic                guide_dn,
    output logic                mul_pulse,
    output logic                sq_out
);
    localparam int MID_STAGES = DIV_STAGES - 1;

    logic [MID_STAGES:0] stage_step;

    rsyn_rate_mult #(.DIGITS(DIGITS)) u_mult (
        .clk     (clk),
        .rst     (rst),
        .bcd_set (bcd_set),
        .pulse_o (mul_pulse)
    );

    assign stage_step[0] = mul_pulse;

    for (genvar g = 0; g < MID_STAGES; g++) begin : g_stage
        if (g == GUIDE_STAGE) begin : g_guided
            rsyn_guided_stage u_stage (
                .clk      (clk),
                .rst      (rst),
                .step_i   (stage_step[g]),
                .guide_up (guide_up),
                .guide_dn (guide_dn),
                .carry_o  (stage_step[g+1])
            );
        end else begin : g_plain
            rsyn_decade u_stage (
                .clk     (clk),
                .rst     (rst),
                .step_i  (stage_step[g]),
                .carry_o (stage_step[g+1])
            );
        end
    end

    rsyn_half_fsm u_final (
        .clk    (clk),
        .rst    (rst),
        .step_i (stage_step[MID_STAGES]),
        .sq_o   (sq_out)
    );

    assert_reset_quiet_R5: assert property (@(posedge clk)
        $past(rst) |-> (!mul_pulse && !sq_out));

endmodule

// File: tb/rate_synth_tb.sv
module rate_synth_tb;
    localparam int DIGITS = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [4*DIGITS-1:0] bcd_set = '0;
    logic                guide_up = 1'b0;
    logic                guide_dn = 1'b0;
    logic                mul_pulse;
    logic                sq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rate_synth #(.DIGITS(DIGITS), .DIV_STAGES(3), .GUIDE_STAGE(1)) u_dut (
        .clk(clk), .rst(rst), .bcd_set(bcd_set),
        .guide_up(guide_up), .guide_dn(guide_dn),
        .mul_pulse(mul_pulse), .sq_out(sq_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [4*DIGITS-1:0] s, input logic up, input logic dn);
        @(negedge clk);
        rst = 1'b1; bcd_set = s; guide_up = up; guide_dn = dn;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_pulses(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mul_pulse) c++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; bcd_set = 12'h999;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 pulse in reset", int'(mul_pulse), 0);
        chk("R5 square in reset", int'(sq_out), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R5 pulse after mid-run reset", int'(mul_pulse), 0);
    endtask

    task automatic t_rate(input string req, input logic [4*DIGITS-1:0] s, input int exp);
        int c;
        apply_reset(s, 1'b0, 1'b0);
        count_pulses(1000, c);
        chk(req, c, exp);
    endtask

    task automatic t_switch();
        int c;
        apply_reset(12'h250, 1'b0, 1'b0);
        c = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (mul_pulse) c++;
            if (i == 400) bcd_set = 12'h731;
            if (i == 998) bcd_set = 12'h046;
        end
        chk("R4 mid-period change ignored", c, 250);
        count_pulses(1000, c);
        chk("R4 change in last cycle taken", c, 46);
    endtask

    task automatic t_chain(input string req, input logic up, input logic dn,
                           input int exp_per, input int exp_hi);
        int   cnt = 0;
        int   phase = 0;
        int   hi = -1;
        int   per = -1;
        logic prev;
        apply_reset(12'h999, up, dn);
        prev = sq_out;
        for (int i = 0; i < 6000 && phase < 3; i++) begin
            @(negedge clk);
            if (sq_out && !prev) begin
                if (phase == 0) begin phase = 1; cnt = 0; end
                else if (phase == 2) begin per = cnt; phase = 3; end
            end else if (!sq_out && prev && phase == 1) begin
                hi = cnt; phase = 2;
            end
            if (mul_pulse) cnt++;
            prev = sq_out;
        end
        chk({req, " period"}, per, exp_per);
        chk({"R8 high half ", req}, hi, exp_hi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rate("R1 setting 500", 12'h500, 500);
        t_rate("R1 setting 123", 12'h123, 123);
        t_rate("R1 setting 999", 12'h999, 999);
        t_rate("R2 zero setting", 12'h000, 0);
        t_rate("R3 digit 15 as 9", 12'h1F0, 190);
        t_rate("R3 all digits 15", 12'hFFF, 999);
        t_switch();
        t_chain("R6 no guide",   1'b0, 1'b0, 1000, 500);
        t_chain("R7 guide up",   1'b1, 1'b0, 900,  450);
        t_chain("R7 guide down", 1'b0, 1'b1, 1100, 550);
        t_chain("R7 both guides", 1'b1, 1'b1, 1000, 500);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule